// File: doc/BRIEF.md
# DPLL Status and Interrupt Register

This block holds the seven-bit status word of a digital phase-locked loop and raises an interrupt when enabled bits of that word change. The operating mode and a set of raw loop indications come in: pull-in in progress, locked, reference activity lost, offset beyond the pull-in range, history update active and history available. A control bit also comes in, selecting whether the loop keeps tracking a reference that is out of range. The block turns these into registered status bits. Bits that only make sense while the loop is timed from an external reference are forced low in the self-timing modes.

Each change of a status bit is found by comparing the word with its value one cycle earlier. If the change is enabled, it sets a sticky pending bit. Software clears a pending bit by writing 1 to it. The interrupt output is registered and reflects any pending bit that is still enabled. A write strobe also produces a single-cycle pulse that flushes the holdover history held elsewhere in the loop.

Status bit positions are: bit 0 locked-and-synchronized, bit 1 reference signal lost, bit 2 lock lost, bit 3 offset out of range, bit 4 stopped tracking, bit 5 history updating, bit 6 history available. The mode encoding is 00 freerun, 01 holdover, 10 slave and 11 synchronized master. The two modes with bit 1 set are the external-timing modes.

Top module: `dpll_status_irq`

## Requirements
- R1: In modes 00 and 01, status bits 0 to 4 read 0 whatever the raw indications are.
- R2: Status bit 0 is 1 one cycle after a cycle in which the mode is external, locked is 1 and pull-in is 0.
- R3: Status bit 1 is 1 one cycle after a cycle in which the mode is external and the reference-lost input is 1.
- R4: Status bit 2 is 1 one cycle after a cycle in which the mode is external, locked is 0 and pull-in is 0. Bits 0 and 2 are therefore both 0 during pull-in and never both 1.
- R5: Status bit 3 is 1 one cycle after a cycle in which the mode is external and the out-of-range input is 1.
- R6: Status bit 4 is 1 one cycle after a cycle in which the mode is external, the out-of-range input is 1 and the follow-out-of-range control is 0. While following is enabled the bit stays 0.
- R7: Status bit 5 follows the history-update input, and bit 6 follows the history-available input, one cycle later in every mode.
- R8: A write with select 10 and data bit 0 set gives a pulse on flush_pulse of exactly one cycle in the cycle after the write. With data bit 0 clear, no pulse appears.
- R9: When a status bit differs from its value one cycle earlier and its enable bit is 1, its pending bit becomes 1 on the next edge and stays 1 until cleared. A change with the enable at 0 leaves the pending bit unchanged.
- R10: A write with select 01 clears the pending bits whose data bits are 1. If an enabled change falls in the same cycle as the clear, the set wins.
- R11: irq is 1 in the cycle after any pending bit has its enable set. Clearing the enable drops irq and leaves pending as it was.
- R12: During reset, status, enables, pending, irq and flush_pulse are all 0.
- R13: A write with select 00 loads the enable register from the data. A write with select 11 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode (00 freerun, 01 holdover, 10 slave, 11 master) |
| pullin | input | 1 | Loop is pulling in |
| locked | input | 1 | Loop reports lock |
| ref_lost | input | 1 | Activity lost on active reference |
| out_of_range | input | 1 | Reference offset beyond pull-in range |
| hist_upd | input | 1 | Holdover history being updated |
| hist_avail | input | 1 | Holdover history available |
| follow_oor | input | 1 | Keep tracking an out-of-range reference |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 enables, 01 pending clear, 10 flush, 11 none |
| wr_data | input | 7 | Write data |
| status | output | 7 | Registered status word |
| irq_en | output | 7 | Interrupt enable register |
| pending | output | 7 | Sticky pending bits |
| irq | output | 1 | Registered active-high interrupt |
| flush_pulse | output | 1 | One-cycle history flush pulse |

## Verification
A change of a status bit that sets its pending bit can fall in the same cycle as a software write that clears that bit. The bench provokes this by toggling the history-available input and then issuing the clear so that it is sampled in the exact cycle the change is seen. It judges the result by requiring the pending bit to stay at 1, and it then checks that a second clear with no change removes the bit. A reference model runs every cycle alongside this and also compares the long pseudo-random mix of mode changes, writes and clears.

// File: rtl/dpll_status_irq.sv
module dpll_status_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       pullin,
  input  logic       locked,
  input  logic       ref_lost,
  input  logic       out_of_range,
  input  logic       hist_upd,
  input  logic       hist_avail,
  input  logic       follow_oor,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [6:0] wr_data,
  output logic [6:0] status,
  output logic [6:0] irq_en,
  output logic [6:0] pending,
  output logic       irq,
  output logic       flush_pulse
);
  localparam logic [1:0] SEL_EN    = 2'd0;
  localparam logic [1:0] SEL_CLR   = 2'd1;
  localparam logic [1:0] SEL_FLUSH = 2'd2;

  logic       ext;
  logic [6:0] st_n, prev_q, chg, clr;

  assign ext  = mode[1];
  assign st_n = {hist_avail,
                 hist_upd,
                 ext & out_of_range & ~follow_oor,
                 ext & out_of_range,
                 ext & ~locked & ~pullin,
                 ext & ref_lost,
                 ext & locked & ~pullin};
  assign chg = status ^ prev_q;
  assign clr = (wr_en && wr_sel == SEL_CLR) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status      <= '0;
      prev_q      <= '0;
      irq_en      <= '0;
      pending     <= '0;
      irq         <= 1'b0;
      flush_pulse <= 1'b0;
    end else begin
      status      <= st_n;
      prev_q      <= status;
      pending     <= (pending & ~clr) | (chg & irq_en);
      irq         <= |(pending & irq_en);
      flush_pulse <= wr_en && wr_sel == SEL_FLUSH && wr_data[0];
      if (wr_en && wr_sel == SEL_EN) irq_en <= wr_data;
    end
  end

  p_selftime_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode[1]) |-> status[4:0] == 5'd0);

  p_sync_lol_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[0] && status[2]));

  p_pullin_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pullin) |-> (!status[0] && !status[2]));

  p_follow_no_sap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(follow_oor) |-> !status[4]);

  p_flush_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(wr_en && wr_sel == SEL_FLUSH && wr_data[0]));

  p_pend_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg & irq_en) != 7'd0 |=> (pending & $past(chg & irq_en)) == $past(chg & irq_en));

  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(pending != 7'd0));
endmodule

// File: tb/tb_dpll_status_irq.sv
`timescale 1ns/1ps
module tb_dpll_status_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic pullin = 0, locked = 0, ref_lost = 0, out_of_range = 0;
  logic hist_upd = 0, hist_avail = 0, follow_oor = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 2'd3;
  logic [6:0] wr_data = '0;
  logic [6:0] status, irq_en, pending;
  logic irq, flush_pulse;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct packed {
    logic [6:0] st;
    logic [6:0] en;
    logic [6:0] pd;
    logic       iq;
    logic       fl;
  } exp_t;
  exp_t q[$];

  logic [6:0] e_st = '0, e_prev = '0, e_en = '0, e_pd = '0;
  logic e_iq = 0, e_fl = 0;

  dpll_status_irq dut (.*);

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      logic ext;
      logic [6:0] ns, chg, clr, npd;
      ext = mode[1];
      ns[0] = ext && locked && !pullin;
      ns[1] = ext && ref_lost;
      ns[2] = ext && !locked && !pullin;
      ns[3] = ext && out_of_range;
      ns[4] = ext && out_of_range && !follow_oor;
      ns[5] = hist_upd;
      ns[6] = hist_avail;
      chg = e_st ^ e_prev;
      clr = (wr_en && wr_sel == 2'd1) ? wr_data : 7'd0;
      npd = (e_pd & ~clr) | (chg & e_en);
      e_iq = |(e_pd & e_en);
      e_fl = wr_en && wr_sel == 2'd2 && wr_data[0];
      if (wr_en && wr_sel == 2'd0) e_en = wr_data;
      e_pd = npd;
      e_prev = e_st;
      e_st = ns;
      q.push_back('{e_st, e_en, e_pd, e_iq, e_fl});
    end
  end

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk("R2 sync", status[0], it.st[0]);
      chk("R3 los", status[1], it.st[1]);
      chk("R4 lol", status[2], it.st[2]);
      chk("R5 oop", status[3], it.st[3]);
      chk("R6 sap", status[4], it.st[4]);
      chk("R7 ahr/hha", status[6:5], it.st[6:5]);
      chk("R13 enable", irq_en, it.en);
      chk("R9 pending", pending, it.pd);
      chk("R11 irq", irq, it.iq);
      chk("R8 flush", flush_pulse, it.fl);
    end
  end

  task automatic wr(logic [1:0] s, logic [6:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic raw(logic [1:0] m, logic pi, logic lk, logic rl, logic oo, logic fo, logic hu, logic ha);
    mode = m; pullin = pi; locked = lk; ref_lost = rl; out_of_range = oo;
    follow_oor = fo; hist_upd = hu; hist_avail = ha;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk("R12 reset", {status, irq_en, pending, irq, flush_pulse}, 0);
    rst_n = 1;
    @(negedge clk);
    wr(2'd0, 7'h7f);
    raw(2'd0, 0, 1, 1, 1, 0, 1, 1);
    chk("R1 freerun gating", status[4:0], 0);
    raw(2'd1, 0, 1, 1, 1, 0, 0, 1);
    chk("R1 holdover gating", status[4:0], 0);
    raw(2'd2, 1, 1, 0, 0, 0, 0, 1);
    chk("R4 pull-in quiet", {status[2], status[0]}, 0);
    raw(2'd2, 0, 1, 0, 0, 0, 0, 1);
    chk("R2 sync in slave", status[0], 1);
    raw(2'd3, 0, 0, 1, 1, 0, 1, 1);
    chk("R6 sap no follow", status[4], 1);
    raw(2'd3, 0, 0, 1, 1, 1, 1, 1);
    chk("R6 sap follow", status[4], 0);
    wr(2'd1, 7'h7f);
    @(negedge clk);
    chk("R10 clear all", pending, 0);
    wr(2'd3, 7'h00);
    chk("R13 sel3 ignored", irq_en, 7'h7f);
    wr(2'd2, 7'h01);
    chk("R8 flush pulse", flush_pulse, 1);
    @(negedge clk);
    chk("R8 flush one cycle", flush_pulse, 0);
    wr(2'd2, 7'h00);
    chk("R8 no flush", flush_pulse, 0);
    hist_avail = 0;
    @(negedge clk);
    @(negedge clk);
    hist_avail = 1;
    @(negedge clk);
    wr(2'd1, 7'h40);
    chk("R10 set wins", pending[6], 1);
    wr(2'd1, 7'h40);
    chk("R10 plain clear", pending[6], 0);
    wr(2'd0, 7'h00);
    hist_upd = ~hist_upd;
    repeat (3) @(negedge clk);
    chk("R9 disabled no set", pending, 0);
    chk("R11 irq low", irq, 0);
    lf = 16'hace1;
    for (int i = 0; i < 2000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[3:0] == 4'd0) mode = lf[5:4];
      pullin = lf[6] & lf[7];
      locked = lf[8];
      ref_lost = lf[9] & lf[10] & lf[11];
      out_of_range = lf[12] & lf[13];
      follow_oor = lf[14];
      if (lf[2:0] == 3'd5) hist_upd = ~hist_upd;
      if (lf[4:0] == 5'd9) hist_avail = ~hist_avail;
      wr_en = lf[15] & lf[1];
      wr_sel = lf[11:10];
      wr_data = lf[7:1];
      @(negedge clk);
    end
    wr_en = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule